// File: doc/BRIEF.md
# Reactive Energy Accumulator with Half-Full Interrupt

The block integrates signed reactive energy for three phases. Each phase has two channels: a total channel and a fundamental channel. That makes six 32-bit signed accumulators. On every clock, an upstream power-to-energy stage may present a step of -1, 0 or +1 to each channel, and all six channels can move in the same cycle. An accumulator wraps silently at full scale. Counting up from the most positive value lands on the most negative value, and counting down does the reverse.

Whenever a step changes bit 30 of an accumulator, the block raises a half-full status flag. There is one flag for the group of total channels and one for the group of fundamental channels. Each flag passes through a mask to a single active-low interrupt pin. The host clears a flag by writing a 1 to its position.

A small register port gives the host several kinds of access:
- It can read any accumulator in the same cycle.
- It can preload an accumulator.
- It can set the mask and a mode register.

When a mode bit is set, reading an accumulator also empties it. This lets the host harvest energy in fixed periods without losing counts.

Top module: `react_energy_accum`

## Requirements
- R1: After reset, the following all read as 0: every accumulator, the status register, the mask register and the mode register. `irq_n_o` is high.
- R2: Each channel has a 2-bit step field: `01` adds 1, `11` subtracts 1, and `00` and `10` leave the accumulator unchanged. The total steps for phases 0..2 sit at bits [1:0], [3:2] and [5:4] of `tot_step_i`, and the fundamental steps sit at the same positions of `fund_step_i`. All six channels update independently in the same cycle.
- R3: Accumulators wrap: +1 on 0x7FFFFFFF gives 0x80000000, and -1 on 0x80000000 gives 0x7FFFFFFF.
- R4: Register addresses are as follows:
  - total accumulator of phase p: address p;
  - fundamental accumulator of phase p: address 4+p;
  - status register: address 8;
  - mask register: address 9;
  - mode register: address 10.
- R4 (continued): `reg_rdata_o` shows the addressed register during the cycle that `reg_rd_i` is high. A host write to an accumulator loads `reg_wdata_i` plus any step applied in that same cycle.
- R5: Status bit 2 is set when a nonzero step changes bit 30 of any total accumulator. Status bit 3 is set the same way for the fundamental accumulators. Host loads and read-clears do not set these bits on their own.
- R6: `irq_n_o` is low exactly when (status AND mask) is nonzero. Only mask bits 2 and 3 are stored.
- R7: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: If a hardware set and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R9: With mode bit 6 set, reading an accumulator returns its value and then zeroes it. With mode bit 6 clear, reads do not change the accumulator.
- R10: If a read-clear and a step hit the same accumulator in the same cycle, the accumulator ends equal to the step (+1 or -1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tot_step_i | input | 6 | Step codes for the three total channels |
| fund_step_i | input | 6 | Step codes for the three fundamental channels |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe |
| reg_addr_i | input | 4 | Host register address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives both together on purpose.

The first pair is a hardware half-full set and a host write-one-to-clear of the same status bit. The bench parks a total accumulator at 0x3FFFFFFF. It then issues a +1 step and a status write of 0x4 in one cycle. Reading status back afterwards must show bit 2 still set.

The second pair is a read-clear and a step on the same accumulator. The read must return the old value, and a later read with the mode off must return exactly the step.

// File: rtl/rea_pkg.sv
package rea_pkg;

  // Status / mask bit positions of the two half-full flags
  localparam int HF_TOT_BIT  = 2;
  localparam int HF_FUND_BIT = 3;
  // Mode bit enabling clear-on-read
  localparam int CLR_RD_BIT  = 6;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_RSV  = 2'b10,
    STEP_DN   = 2'b11
  } step_e;

  // Size of one address group (power of two covering the phases)
  function automatic int grp_size(input int nph);
    return 1 << $clog2(nph);
  endfunction

  // Address of accumulator channel c: totals first, fundamentals one group up
  function automatic int chan_addr(input int c, input int nph);
    if (c < nph) return c;
    return grp_size(nph) + (c - nph);
  endfunction

endpackage

// File: rtl/rea_chan.sv
module rea_chan
  import rea_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    step_i,
  input  logic          ld_i,
  input  logic [EW-1:0] ld_val_i,
  input  logic          clr_i,
  output logic [EW-1:0] acc_o,
  output logic          half_o
);

  localparam int HB = EW - 2;

  logic [EW-1:0] acc_q;
  logic [EW-1:0] acc_d;
  logic [EW-1:0] base;
  logic [EW-1:0] delta;
  logic          move;
  logic          acc_en;

  // Next-state: pick the base (load, clear or hold), then add the step
  always_comb begin
    move  = (step_i == STEP_UP) || (step_i == STEP_DN);
    delta = '0;
    if (step_i == STEP_UP) begin
      delta = {{(EW-1){1'b0}}, 1'b1};
    end else if (step_i == STEP_DN) begin
      delta = '1;
    end
    if (ld_i) begin
      base = ld_val_i;
    end else if (clr_i) begin
      base = '0;
    end else begin
      base = acc_q;
    end
    acc_d  = base + delta;
    acc_en = move | ld_i | clr_i;
    half_o = move && (base[HB] != acc_d[HB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/rea_regif.sv
module rea_regif
  import rea_pkg::*;
#(
  parameter int NPH = 3,
  parameter int EW  = 32,
  parameter int AW  = 4
) (
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [AW-1:0]            addr_i,
  input  logic                     clr_on_rd_i,
  input  logic [2*NPH-1:0][EW-1:0] acc_i,
  input  logic [EW-1:0]            status_i,
  input  logic [EW-1:0]            mask_i,
  input  logic [EW-1:0]            mode_i,
  output logic [2*NPH-1:0]         ld_o,
  output logic [2*NPH-1:0]         clr_o,
  output logic                     stat_we_o,
  output logic                     mask_we_o,
  output logic                     mode_we_o,
  output logic [EW-1:0]            rdata_o
);

  localparam int          NCH    = 2 * NPH;
  localparam int          GRP    = grp_size(NPH);
  localparam logic [AW-1:0] STAT_A = AW'(2 * GRP);
  localparam logic [AW-1:0] MASK_A = AW'(2 * GRP + 1);
  localparam logic [AW-1:0] MODE_A = AW'(2 * GRP + 2);

  always_comb begin
    rdata_o = '0;
    ld_o    = '0;
    clr_o   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(chan_addr(c, NPH))) begin
        rdata_o  = acc_i[c];
        ld_o[c]  = wr_i;
        clr_o[c] = rd_i && clr_on_rd_i;
      end
    end
    if (addr_i == STAT_A) rdata_o = status_i;
    if (addr_i == MASK_A) rdata_o = mask_i;
    if (addr_i == MODE_A) rdata_o = mode_i;
    stat_we_o = wr_i && (addr_i == STAT_A);
    mask_we_o = wr_i && (addr_i == MASK_A);
    mode_we_o = wr_i && (addr_i == MODE_A);
  end

endmodule

// File: rtl/rea_irq.sv
module rea_irq
  import rea_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_tot_i,
  input  logic          set_fund_i,
  input  logic          stat_we_i,
  input  logic          mask_we_i,
  input  logic          mode_we_i,
  input  logic [1:0]    hf_wdata_i,
  input  logic          mode_wdata_i,
  output logic [EW-1:0] status_o,
  output logic [EW-1:0] mask_o,
  output logic [EW-1:0] mode_o,
  output logic          clr_on_rd_o,
  output logic          irq_n_o
);

  // Index 0: total half-full, index 1: fundamental half-full
  logic [1:0] st_q, st_d;
  logic [1:0] mk_q, mk_d;
  logic       cor_q, cor_d;
  logic [1:0] w1c;

  always_comb begin
    w1c   = stat_we_i ? hf_wdata_i : 2'b00;
    // a hardware set beats a host clear in the same cycle
    st_d  = (st_q & ~w1c) | {set_fund_i, set_tot_i};
    mk_d  = mask_we_i ? hf_wdata_i : mk_q;
    cor_d = mode_we_i ? mode_wdata_i : cor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 2'b00;
      mk_q  <= 2'b00;
      cor_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      mk_q  <= mk_d;
      cor_q <= cor_d;
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[HF_TOT_BIT]  = st_q[0];
    status_o[HF_FUND_BIT] = st_q[1];
    mask_o                = '0;
    mask_o[HF_TOT_BIT]    = mk_q[0];
    mask_o[HF_FUND_BIT]   = mk_q[1];
    mode_o                = '0;
    mode_o[CLR_RD_BIT]    = cor_q;
  end

  assign clr_on_rd_o = cor_q;
  assign irq_n_o     = ~|(st_q & mk_q);

endmodule

// File: rtl/react_energy_accum.sv
module react_energy_accum
  import rea_pkg::*;
#(
  parameter int NPH = 3,
  parameter int EW  = 32,
  parameter int AW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*NPH-1:0] tot_step_i,
  input  logic [2*NPH-1:0] fund_step_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [EW-1:0]    reg_wdata_i,
  output logic [EW-1:0]    reg_rdata_o,
  output logic             irq_n_o
);

  localparam int NCH = 2 * NPH;

  logic [NCH-1:0][1:0]    step;
  logic [NCH-1:0][EW-1:0] acc;
  logic [NCH-1:0]         ld_en;
  logic [NCH-1:0]         clr_en;
  logic [NCH-1:0]         half;
  logic                   half_tot;
  logic                   half_fund;
  logic                   stat_we;
  logic                   mask_we;
  logic                   mode_we;
  logic                   clr_on_rd;
  logic [EW-1:0]          status_w;
  logic [EW-1:0]          mask_w;
  logic [EW-1:0]          mode_w;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    if (c < NPH) begin : g_tot
      assign step[c] = tot_step_i[2*c +: 2];
    end else begin : g_fund
      assign step[c] = fund_step_i[2*(c-NPH) +: 2];
    end

    rea_chan #(.EW(EW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step[c]),
      .ld_i     (ld_en[c]),
      .ld_val_i (reg_wdata_i),
      .clr_i    (clr_en[c]),
      .acc_o    (acc[c]),
      .half_o   (half[c])
    );
  end

  assign half_tot  = |half[NPH-1:0];
  assign half_fund = |half[NCH-1:NPH];

  rea_regif #(.NPH(NPH), .EW(EW), .AW(AW)) u_regif (
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .clr_on_rd_i (clr_on_rd),
    .acc_i       (acc),
    .status_i    (status_w),
    .mask_i      (mask_w),
    .mode_i      (mode_w),
    .ld_o        (ld_en),
    .clr_o       (clr_en),
    .stat_we_o   (stat_we),
    .mask_we_o   (mask_we),
    .mode_we_o   (mode_we),
    .rdata_o     (reg_rdata_o)
  );

  rea_irq #(.EW(EW)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_tot_i    (half_tot),
    .set_fund_i   (half_fund),
    .stat_we_i    (stat_we),
    .mask_we_i    (mask_we),
    .mode_we_i    (mode_we),
    .hf_wdata_i   (reg_wdata_i[HF_FUND_BIT:HF_TOT_BIT]),
    .mode_wdata_i (reg_wdata_i[CLR_RD_BIT]),
    .status_o     (status_w),
    .mask_o       (mask_w),
    .mode_o       (mode_w),
    .clr_on_rd_o  (clr_on_rd),
    .irq_n_o      (irq_n_o)
  );

endmodule

// File: rtl/rea_chk.sv
module rea_chk
  import rea_pkg::*;
#(
  parameter int NPH = 3,
  parameter int EW  = 32,
  parameter int AW  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2*NPH-1:0][1:0]    step,
  input logic [2*NPH-1:0][EW-1:0] acc,
  input logic [2*NPH-1:0]         ld_en,
  input logic [2*NPH-1:0]         clr_en,
  input logic [2*NPH-1:0]         half,
  input logic [1:0]               stat_hf,
  input logic                     reg_wr,
  input logic [AW-1:0]            reg_addr,
  input logic                     irq_n
);

  localparam int            NCH    = 2 * NPH;
  localparam logic [AW-1:0] STAT_A = AW'(2 * grp_size(NPH));
  localparam logic [AW-1:0] MASK_A = AW'(2 * grp_size(NPH) + 1);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    localparam int FI = (c < NPH) ? 0 : 1;

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en[c] && !clr_en[c] && step[c] == 2'b01) |=> (acc[c] == $past(acc[c]) + EW'(1))); // R2

    AST_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en[c] && !clr_en[c] && step[c] == 2'b11) |=> (acc[c] == $past(acc[c]) - EW'(1))); // R3

    AST_CLR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en[c] && !ld_en[c] && step[c][0] == 1'b0) |=> (acc[c] == '0)); // R9

    AST_CLR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en[c] && !ld_en[c] && step[c] == 2'b01) |=> (acc[c] == EW'(1))); // R10

    AST_HALF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc[c][EW-2] != $past(acc[c][EW-2])) && $past(!ld_en[c] && !clr_en[c])) |-> stat_hf[FI]); // R5
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|half[NPH-1:0]) |=> stat_hf[0]); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(reg_wr && (reg_addr == STAT_A || reg_addr == MASK_A))) |=> !irq_n); // R6

endmodule

bind react_energy_accum rea_chk #(.NPH(NPH), .EW(EW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step),
  .acc      (acc),
  .ld_en    (ld_en),
  .clr_en   (clr_en),
  .half     (half),
  .stat_hf  (status_w[3:2]),
  .reg_wr   (reg_wr_i),
  .reg_addr (reg_addr_i),
  .irq_n    (irq_n_o)
);

// File: tb/react_energy_accum_bench.sv
module react_energy_accum_bench;

  localparam int NPH = 3;
  localparam int NCH = 6;
  localparam int EW  = 32;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [5:0]    tot_step_i;
  logic [5:0]    fund_step_i;
  logic          reg_wr_i;
  logic          reg_rd_i;
  logic [3:0]    reg_addr_i;
  logic [31:0]   reg_wdata_i;
  logic [31:0]   reg_rdata_o;
  logic          irq_n_o;

  always #2 clk = ~clk;

  react_energy_accum #(.NPH(NPH), .EW(EW), .AW(AW)) u_react_energy_accum (
    .clk(clk), .rst_n(rst_n),
    .tot_step_i(tot_step_i), .fund_step_i(fund_step_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
  );

  typedef struct {
    bit          has_rd;
    logic [31:0] rd_exp;
    bit          irq_exp;
    string       tag;
  } item_t;

  item_t       sbq[$];
  item_t       mon_it;
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;
  logic [31:0] m_acc[NCH];
  logic [31:0] m_st, m_mk, m_md;

  function automatic logic [3:0] ca(input int c);
    return (c < 3) ? 4'(c) : 4'(4 + c - 3);
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [31:0] v;
    v = 32'h0;
    for (int c = 0; c < NCH; c++) if (a == ca(c)) v = m_acc[c];
    if (a == 4'd8)  v = m_st;
    if (a == 4'd9)  v = m_mk;
    if (a == 4'd10) v = m_md;
    return v;
  endfunction

  // Scoreboard monitor: one expected item per driven cycle
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      mon_it = sbq.pop_front();
      if (mon_it.has_rd) begin
        n_chk++;
        if (reg_rdata_o !== mon_it.rd_exp) begin
          n_fail++;
          $display("FAIL %s rdata actual %h expected %h", mon_it.tag, reg_rdata_o, mon_it.rd_exp);
        end
      end
      n_chk++;
      if (irq_n_o !== mon_it.irq_exp) begin
        n_fail++;
        $display("FAIL R6 irq_n actual %b expected %b", irq_n_o, mon_it.irq_exp);
      end
    end
  end

  // Driver: one cycle of stimulus, expected item pushed, model advanced
  task automatic cyc(input logic [5:0] ts, input logic [5:0] fs, input bit wr, input bit rd,
                     input logic [3:0] a, input logic [31:0] wd, input string tag);
    item_t       it;
    logic [31:0] base, nx, d, sets;
    logic [1:0]  s;
    @(posedge clk); #1;
    tot_step_i  = ts;
    fund_step_i = fs;
    reg_wr_i    = wr;
    reg_rd_i    = rd;
    reg_addr_i  = a;
    reg_wdata_i = wd;
    it.has_rd  = rd;
    it.rd_exp  = model_read(a);
    it.irq_exp = ((m_st & m_mk) == 32'h0);
    it.tag     = tag;
    sbq.push_back(it);
    sets = 32'h0;
    for (int c = 0; c < NCH; c++) begin
      s = (c < 3) ? ts[2*c +: 2] : fs[2*(c-3) +: 2];
      d = (s == 2'b01) ? 32'h1 : (s == 2'b11) ? 32'hFFFF_FFFF : 32'h0;
      if (wr && a == ca(c))                    base = wd;
      else if (rd && a == ca(c) && m_md[6])    base = 32'h0;
      else                                     base = m_acc[c];
      nx = base + d;
      if (d != 0 && base[30] != nx[30]) sets |= (c < 3) ? 32'h4 : 32'h8;
      m_acc[c] = nx;
    end
    m_st = ((m_st & ~((wr && a == 4'd8) ? wd : 32'h0)) | sets) & 32'hC;
    if (wr && a == 4'd9)  m_mk = wd & 32'hC;
    if (wr && a == 4'd10) m_md = wd & 32'h40;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(6'b0, 6'b0, 1'b1, 1'b0, a, d, "WR");
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(6'b0, 6'b0, 1'b0, 1'b1, a, 32'h0, tag);
  endtask

  task automatic stp(input logic [5:0] ts, input logic [5:0] fs, input int n);
    for (int i = 0; i < n; i++) cyc(ts, fs, 1'b0, 1'b0, 4'd0, 32'h0, "STEP");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tot_step_i = '0; fund_step_i = '0;
    reg_wr_i = 1'b0; reg_rd_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    for (int c = 0; c < NCH; c++) m_acc[c] = 32'h0;
    m_st = 0; m_mk = 0; m_md = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (irq_n_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 irq_n after reset actual %b expected 1", irq_n_o);
    end
    // R1: every register reads zero after reset
    foreach (m_acc[c]) rd(ca(c), "R1");
    rd(4'd8, "R1"); rd(4'd9, "R1"); rd(4'd10, "R1");

    // R2: all six channels at once, including the ignored code 10
    stp(6'b00_11_01, 6'b11_01_10, 5);
    for (int c = 0; c < NCH; c++) rd(ca(c), "R2");

    // R4: preload, and preload combined with a step
    wr(4'd0, 32'h7FFF_FFFE);
    rd(4'd0, "R4");
    cyc(6'b0, 6'b00_00_01, 1'b1, 1'b0, 4'd4, 32'h0000_0100, "R4");
    rd(4'd4, "R4");

    // R3: wrap in both directions
    stp(6'b00_00_01, 6'b0, 1); rd(4'd0, "R3");
    stp(6'b00_00_01, 6'b0, 2); rd(4'd0, "R3");
    wr(4'd5, 32'h8000_0001);
    stp(6'b0, 6'b00_11_00, 2); rd(4'd5, "R3");

    // R7: clear everything set so far
    wr(4'd8, 32'hC); rd(4'd8, "R7");

    // R5: a load alone does not flag; a crossing step does
    wr(4'd2, 32'h3FFF_FFFF); rd(4'd8, "R5");
    stp(6'b01_00_00, 6'b0, 1); rd(4'd8, "R5");
    wr(4'd6, 32'hC000_0000);
    stp(6'b0, 6'b11_00_00, 1); rd(4'd8, "R5");

    // R6: mask drives the pin
    wr(4'd9, 32'h4); rd(4'd9, "R6");
    stp(6'b0, 6'b0, 2);

    // R7: write one clears, write zero keeps
    wr(4'd8, 32'h8); rd(4'd8, "R7");
    wr(4'd8, 32'h0); rd(4'd8, "R7");
    wr(4'd8, 32'h4); rd(4'd8, "R7");

    // R8: set and clear collide on bit 2
    wr(4'd2, 32'h3FFF_FFFF);
    cyc(6'b01_00_00, 6'b0, 1'b1, 1'b0, 4'd8, 32'h4, "R8");
    rd(4'd8, "R8");
    wr(4'd8, 32'hC);

    // R9: clear-on-read on and off
    wr(4'd10, 32'h40); rd(4'd10, "R9");
    rd(4'd0, "R9"); rd(4'd0, "R9");
    wr(4'd10, 32'h0);
    rd(4'd4, "R9"); rd(4'd4, "R9");

    // R10: read-clear collides with a step
    wr(4'd10, 32'h40);
    cyc(6'b00_01_00, 6'b0, 1'b0, 1'b1, 4'd1, 32'h0, "R10");
    cyc(6'b0, 6'b11_00_00, 1'b0, 1'b1, 4'd6, 32'h0, "R10");
    wr(4'd10, 32'h0);
    rd(4'd1, "R10"); rd(4'd6, "R10"); rd(4'd8, "R10");

    stp(6'b0, 6'b0, 2);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule